// File: doc/BRIEF.md
# Warp Load Coalescer

This block takes one load request from a group of 32 parallel lanes and turns it into the fewest aligned memory transactions that cover every active lane. Each lane asks for one 4-byte word at a 4-byte aligned byte address, and an active mask says which lanes take part. Lanes whose words fall in the same 128-byte aligned segment share one transaction. That transaction is then trimmed to the smallest aligned 64-byte or 32-byte block that still holds every word touched in the segment. It is never trimmed below 32 bytes. Bytes fetched that no lane asked for are left for the consumer to drop.

Requests enter on a valid/ready port. A request is taken when `req_valid` and `req_ready` are both high on a rising clock edge. `req_ready` then stays low until the last transaction of that request has been accepted. Transactions leave one at a time on a second valid/ready port. While `txn_valid` is high and `txn_ready` is low, the offered transaction is held unchanged, so the consumer can apply back-pressure for any number of cycles. Segments are emitted in the order of their lowest-numbered still-pending active lane. A one-cycle `done` pulse marks the end of each request.

Top module: `warp_coalescer`

## Requirements
- R1: All pending active lanes whose addresses share bits [31:7] with the leading lane are served by one transaction. Across a request, every active lane appears in exactly one transaction's `txn_lanes`.
- R2: The next transaction is always built around the lowest-numbered active lane not yet served. Its `txn_lanes` bit is set, and no lower lane is still pending.
- R3: If every touched word of a segment lies in one aligned 32-byte block, the transaction has `txn_size` = 0. Its `txn_base` is that block's address, with bits [4:0] zero.
- R4: Otherwise, if every touched word lies in one aligned 64-byte half of the segment, `txn_size` = 1 and `txn_base` is that half's address, with bits [5:0] zero.
- R5: Otherwise `txn_size` = 2 and `txn_base` is the 128-byte segment address, with bits [6:0] zero. This holds for any stride inside the segment.
- R6: Lanes with a 0 in `req_mask` are never placed in any transaction. A request with an all-zero mask produces no transaction at all.
- R7: `req_ready` is high when idle. It stays low from the cycle after a request is accepted until the last transaction of that request is accepted.
- R8: While `txn_valid` is high and `txn_ready` is low, the next cycle still has `txn_valid` high, with `txn_base`, `txn_size` and `txn_lanes` unchanged.
- R9: `done` is high for exactly the one cycle after the last transaction of a request is accepted. For an all-zero mask, it is high in the cycle after the request is accepted. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Coalescer idle and able to take a request |
| req_addr | input | 1024 | Lane byte addresses, lane i in bits [32i+31:32i] |
| req_mask | input | 32 | Active lanes, bit i for lane i |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Consumer takes the transaction |
| txn_base | output | 32 | Aligned start address of the transaction |
| txn_size | output | 2 | 0 = 32 bytes, 1 = 64 bytes, 2 = 128 bytes |
| txn_lanes | output | 32 | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse after a request's last transaction |

## Verification
The assertions assume every active lane address is 4-byte aligned. They also assume the consumer only ever lowers `txn_ready` and never withdraws a transaction itself. An input check flags any active lane address with nonzero low bits when a request is taken. The stimulus builds every address as a word-aligned start plus a whole number of words, so that check never fires. Back-pressure comes from a pseudo-random `txn_ready`, and the hold rules cover every stall it creates.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {
    SZ_32  = 2'd0,
    SZ_64  = 2'd1,
    SZ_128 = 2'd2
  } txn_size_e;
endpackage

// File: rtl/coal_leader.sv
// Finds the lowest-numbered pending lane; it anchors the next segment.
module coal_leader #(
  parameter int N = 32
) (
  input  logic [N-1:0]         pend,
  output logic [$clog2(N)-1:0] idx,
  output logic                 any
);
  localparam int LW = $clog2(N);

  always_comb begin
    idx = '0;
    any = |pend;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = LW'(i);
    end
  end
endmodule

// File: rtl/coal_group.sv
// Groups pending lanes into the leader's segment and trims the segment size.
module coal_group
  import coal_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32
) (
  input  logic [LANES*ADDR_W-1:0] addrs,
  input  logic [LANES-1:0]        pend,
  input  logic [$clog2(LANES)-1:0] lead,
  output logic [LANES-1:0]        lanes,
  output logic [ADDR_W-1:0]       base,
  output txn_size_e               size,
  output logic                    misal
);
  localparam int SEG_LSB   = 7;
  localparam int MIN_LSB   = 5;
  localparam int WORD_LSB  = 2;
  localparam int NWORDS    = 1 << (SEG_LSB - WORD_LSB);
  localparam int NBLK      = 1 << (SEG_LSB - MIN_LSB);
  localparam int BLK_WORDS = NWORDS / NBLK;
  localparam int HALF      = NBLK / 2;
  localparam int BW        = SEG_LSB - MIN_LSB;

  logic [ADDR_W-1:0]         a [LANES];
  logic [ADDR_W-SEG_LSB-1:0] seg;
  logic [NWORDS-1:0]         touched;
  logic [NBLK-1:0]           blk;
  logic [BW-1:0]             blk_id;
  logic [LANES-1:0]          low_bits;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign a[i]        = addrs[i*ADDR_W +: ADDR_W];
    assign lanes[i]    = pend[i] && (a[i][ADDR_W-1:SEG_LSB] == seg);
    assign low_bits[i] = pend[i] && (|a[i][WORD_LSB-1:0]);
  end

  assign seg   = a[lead][ADDR_W-1:SEG_LSB];
  assign misal = |low_bits;

  always_comb begin
    touched = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lanes[i]) touched[a[i][SEG_LSB-1:WORD_LSB]] = 1'b1;
    end
  end

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign blk[b] = |touched[b*BLK_WORDS +: BLK_WORDS];
  end

  always_comb begin
    blk_id = '0;
    for (int b = NBLK - 1; b >= 0; b--) begin
      if (blk[b]) blk_id = BW'(b);
    end
  end

  always_comb begin
    base = {seg, {SEG_LSB{1'b0}}};
    if ($countones(blk) == 1) begin
      size = SZ_32;
      base[SEG_LSB-1:MIN_LSB] = blk_id;
    end else if (blk[NBLK-1:HALF] == '0) begin
      size = SZ_64;
    end else if (blk[HALF-1:0] == '0) begin
      size = SZ_64;
      base[SEG_LSB-1] = 1'b1;
    end else begin
      size = SZ_128;
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_mask,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_base,
  output logic [1:0]              txn_size,
  output logic [LANES-1:0]        txn_lanes,
  output logic                    done
);
  localparam int LW = $clog2(LANES);

  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        pend_q;
  logic                    busy_q;
  logic                    done_q;
  logic [LW-1:0]           lead;
  logic                    any;
  txn_size_e               size;
  logic                    misal;
  logic                    accept;
  logic                    fire;
  logic [LANES-1:0]        pend_next;

  coal_leader #(.N(LANES)) u_leader (
    .pend (pend_q),
    .idx  (lead),
    .any  (any)
  );

  coal_group #(.LANES(LANES), .ADDR_W(ADDR_W)) u_group (
    .addrs (addr_q),
    .pend  (pend_q),
    .lead  (lead),
    .lanes (txn_lanes),
    .base  (txn_base),
    .size  (size),
    .misal (misal)
  );

  assign req_ready = !busy_q;
  assign txn_valid = busy_q && any;
  assign txn_size  = size;
  assign done      = done_q;
  assign accept    = req_valid && req_ready;
  assign fire      = txn_valid && txn_ready;
  assign pend_next = pend_q & ~txn_lanes;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      pend_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        addr_q <= req_addr;
        pend_q <= req_mask;
        busy_q <= |req_mask;
        done_q <= (req_mask == '0);
      end else if (fire) begin
        pend_q <= pend_next;
        if (pend_next == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // Input rule: active lane addresses are word aligned
  logic [LANES-1:0] req_low;
  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assign req_low[i] = req_mask[i] && (|req_addr[i*ADDR_W +: 2]);
  end
  aligned_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (req_low == '0));
  pend_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !misal);

  // R2
  lead_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_lanes[lead] &&
      ((pend_q & ((LANES'(1) << lead) - LANES'(1))) == '0)));
  // R6
  lanes_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_lanes != '0) && ((txn_lanes & ~pend_q) == '0)));
  // R3
  base32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_size == 2'd0) |-> (txn_base[4:0] == 5'd0));
  // R4
  base64_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_size == 2'd1) |-> (txn_base[5:0] == 6'd0));
  // R5
  base128_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_size == 2'd2) |-> (txn_base[6:0] == 7'd0));
  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);
  // R8
  txn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) &&
      $stable(txn_size) && $stable(txn_lanes)));
  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(txn_valid && txn_ready) ||
      $past(req_valid && req_ready && req_mask == '0)));
endmodule

// File: tb/test_warp_coalescer.sv
`timescale 1ns/1ps
module test_warp_coalescer;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1023:0] req_addr = '0;
  logic [31:0]   req_mask = '0;
  logic          txn_valid;
  logic          txn_ready = 1'b0;
  logic [31:0]   txn_base;
  logic [1:0]    txn_size;
  logic [31:0]   txn_lanes;
  logic          done;

  int compared = 0;
  int mismatched = 0;

  logic [31:0] cur_addr [32];
  logic [31:0] cur_mask;
  logic [31:0] exp_base [32];
  logic [1:0]  exp_size [32];
  logic [31:0] exp_lanes [32];
  int          nexp;

  always #2 clk = ~clk;

  warp_coalescer i_warp_coalescer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_base(txn_base), .txn_size(txn_size),
    .txn_lanes(txn_lanes), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: group by segment, then size from lowest and highest touched byte
  task automatic build_exp();
    logic [31:0] pend = cur_mask;
    nexp = 0;
    while (pend != 0) begin
      int lead = 0;
      logic [24:0] seg;
      logic [31:0] lanes = 0;
      int lo = 127;
      int hi = 0;
      for (int i = 31; i >= 0; i--) if (pend[i]) lead = i;
      seg = cur_addr[lead][31:7];
      for (int i = 0; i < 32; i++) begin
        if (pend[i] && cur_addr[i][31:7] == seg) begin
          int off = int'(cur_addr[i][6:0]);
          lanes[i] = 1'b1;
          if (off < lo) lo = off;
          if (off + 3 > hi) hi = off + 3;
        end
      end
      if (lo / 32 == hi / 32) begin
        exp_size[nexp] = 2'd0;
        exp_base[nexp] = {seg, 7'd0} + 32'(lo / 32 * 32);
      end else if (lo / 64 == hi / 64) begin
        exp_size[nexp] = 2'd1;
        exp_base[nexp] = {seg, 7'd0} + 32'(lo / 64 * 64);
      end else begin
        exp_size[nexp] = 2'd2;
        exp_base[nexp] = {seg, 7'd0};
      end
      exp_lanes[nexp] = lanes;
      pend &= ~lanes;
      nexp++;
    end
  endtask

  task automatic run_req();
    int idx = 0;
    build_exp();
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready when idle", 64'(req_ready), 64'd1);
    chk(done == 1'b0, "R9 done low between requests", 64'(done), 64'd0);
    for (int i = 0; i < 32; i++) req_addr[i*32 +: 32] = cur_addr[i];
    req_mask  = cur_mask;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (idx < nexp) begin
      bit rdy;
      logic [31:0] hb, hl;
      logic [1:0]  hs;
      chk(req_ready == 1'b0, "R7 ready low while busy", 64'(req_ready), 64'd0);
      chk(done == 1'b0, "R9 done low while busy", 64'(done), 64'd0);
      if (!txn_valid) begin
        chk(1'b0, "R1 transaction missing", 64'(txn_valid), 64'd1);
        break;
      end
      rdy = ($urandom_range(3) != 0);
      txn_ready = rdy;
      hb = txn_base; hs = txn_size; hl = txn_lanes;
      if (rdy) begin
        string st;
        st = (exp_size[idx] == 2'd0) ? "R3" : (exp_size[idx] == 2'd1) ? "R4" : "R5";
        chk(txn_lanes == exp_lanes[idx], "R1/R2/R6 lanes", 64'(txn_lanes), 64'(exp_lanes[idx]));
        chk(txn_size == exp_size[idx], {st, " size"}, 64'(txn_size), 64'(exp_size[idx]));
        chk(txn_base == exp_base[idx], {st, " base"}, 64'(txn_base), 64'(exp_base[idx]));
        idx++;
      end
      @(negedge clk);
      if (!rdy) begin
        chk(txn_valid && txn_base == hb && txn_size == hs && txn_lanes == hl,
            "R8 hold under back-pressure", {txn_base, txn_lanes}, {hb, hl});
      end
    end
    txn_ready = 1'b0;
    chk(done == 1'b1, "R9 done after last transaction", 64'(done), 64'd1);
    chk(txn_valid == 1'b0, "R6 no extra transaction", 64'(txn_valid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] starts [5];
    logic [31:0] masks [4];
    starts = '{32'h0, 32'h4, 32'h3C, 32'h7C, 32'h1000_0040};
    masks  = '{32'hFFFF_FFFF, 32'h5555_5555, 32'h8000_0001, 32'h0000_00F0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && txn_valid == 1'b0 && done == 1'b0,
        "R7 reset state", {req_ready, txn_valid, done}, 64'h4);

    // R5: fully contiguous warp, one 128-byte fetch
    for (int i = 0; i < 32; i++) cur_addr[i] = 32'h2000 + 32'(4 * i);
    cur_mask = '1;
    run_req();
    // R1: stride of two words, two segments
    for (int i = 0; i < 32; i++) cur_addr[i] = 32'h4000 + 32'(8 * i);
    run_req();
    // R3: scattered, each lane its own 32-byte fetch
    for (int i = 0; i < 32; i++)
      cur_addr[i] = 32'(i * 4096) + 32'((i * 36) % 128) & 32'hFFFF_FFFC;
    run_req();
    // R6: all-inactive mask
    cur_mask = '0;
    run_req();
    // R3: broadcast to one word
    for (int i = 0; i < 32; i++) cur_addr[i] = 32'h8888;
    cur_mask = '1;
    run_req();
    // R4: sixteen words in the upper half of a segment
    for (int i = 0; i < 32; i++) cur_addr[i] = 32'h9040 + 32'(4 * (i % 16));
    run_req();
    // R2: reversed lane order across segments
    for (int i = 0; i < 32; i++) cur_addr[i] = 32'h10000 + 32'(128 * (31 - i) / 2);
    run_req();

    // Sweep of strides, start offsets and masks
    for (int s = 0; s < 34; s++)
      for (int o = 0; o < 5; o++)
        for (int m = 0; m < 4; m++) begin
          for (int i = 0; i < 32; i++) cur_addr[i] = starts[o] + 32'(4 * s * i);
          cur_mask = masks[m];
          run_req();
        end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule